// File: doc/BRIEF.md
# Restart-Vector Interrupt Controller

This block sits between up to eight interrupting devices and an 8-bit processor whose interrupt-acknowledge cycle is an ordinary opcode fetch. Each device line is captured on its rising edge and kept pending until it is serviced. The block raises one interrupt line toward the processor whenever an unmasked request is pending and the processor reports that its interrupts are enabled.

When the processor runs the acknowledge fetch, the block chooses the lowest-numbered pending unmasked request. It places a one-byte restart instruction for that request on the data bus. The instruction sends the processor to a handler at eight times the request number. When the strobe ends, the block clears the chosen request and reports for one cycle which request was serviced. Software sets a per-line mask through a small write port. A masked line is still captured but is held back from the interrupt line and from selection.

Top module: `rst_vector_intc`

## Requirements
- R1: After reset, int_o, vec_oe_o, vec_o and served_vld_o are 0, no request is pending, and the mask is all zeros, so every line is unmasked.
- R2: A 0-to-1 transition on req_i[n] makes request n pending. A line held high does not become pending again after it has been serviced, until it goes low and rises again.
- R3: int_o is a registered signal. It equals, one clock later, cpu_ie_i AND (at least one pending request whose mask bit is 0). It therefore drops within one clock of cpu_ie_i going low.
- R4: In the first clock in which ack_i is sampled high, the lowest-indexed pending unmasked request is chosen. That choice is frozen until ack_i is low again, even if new requests arrive meanwhile.
- R5: While vec_oe_o is 1 and a request n was chosen, vec_o equals C7h + 8*n. Bits [5:3] then hold n, so the handler address is n*8 (request 4 gives 0020h).
- R6: vec_oe_o is 1 only while ack_i is high, starting in the clock after the one in which ack_i was first sampled high. While vec_oe_o is 0, vec_o is 00h.
- R7: In the clock after ack_i is sampled low at the end of a strobe, the chosen request is no longer pending. In that same clock served_vld_o is 1 for exactly one cycle, with served_idx_o = n.
- R8: When mask_we_i is 1 at a clock edge, the mask becomes mask_wdata_i. Bit n = 1 masks request n. A masked request is still captured: it drives neither int_o nor selection, and it does both once unmasked.
- R9: If nothing is pending and unmasked when the strobe starts, vec_o is 00h (no-operation) while vec_oe_o is 1. Nothing is cleared and served_vld_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Device request lines, captured on rising edge |
| cpu_ie_i | input | 1 | Processor interrupt-enable status |
| ack_i | input | 1 | Acknowledge-fetch strobe, active high |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 8 | New mask value, 1 = masked |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Restart opcode for the data bus |
| vec_oe_o | output | 1 | Drive enable for vec_o |
| served_idx_o | output | 3 | Index of the last serviced request |
| served_vld_o | output | 1 | One-cycle pulse when a request is serviced |

## Verification
The hardest case to reach is a new, higher-priority edge that arrives while an acknowledge strobe is already open. The choice must stay frozen, and the newcomer must be served on the next strobe. A directed sequence builds this case. Random strobes of varying length, laid over sparse random request edges, then reproduce it many times. The random runs also overlap a rising edge with the clearing edge on the same line, and issue mask writes in the middle of a strobe. A cycle model written from the requirements predicts every output in every clock.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
    localparam int NREQ = 8;
    localparam int IDXW = $clog2(NREQ);
    localparam int BUSW = 8;
    localparam logic [BUSW-1:0] OP_BASE = 8'hC7;
    localparam logic [BUSW-1:0] OP_IDLE = 8'h00;

    typedef struct packed {
        logic [NREQ-1:0] mask;
        logic            int_r;
        logic            active;
        logic            selv;
        logic [IDXW-1:0] sel;
        logic            svld;
        logic [IDXW-1:0] sidx;
    } ctl_t;

    function automatic logic [BUSW-1:0] rst_opcode(input logic [IDXW-1:0] idx);
        logic [BUSW-1:0] sh;
        sh = BUSW'(idx) << 3;
        return OP_BASE | sh;
    endfunction
endpackage

// File: rtl/rvc_edge_latch.sv
module rvc_edge_latch
    import rvc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] clr_i,
    output logic [NREQ-1:0] pending_o
);
    typedef struct packed {
        logic [NREQ-1:0] prev;
        logic [NREQ-1:0] pend;
    } el_t;

    el_t el_d, el_q;

    always_comb begin
        el_d      = el_q;
        el_d.prev = req_i;
        el_d.pend = (el_q.pend & ~clr_i) | (req_i & ~el_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) el_q <= '0;
        else        el_q <= el_d;
    end

    assign pending_o = el_q.pend;

    for (genvar k = 0; k < NREQ; k++) begin : g_chk
        // R2
        edge_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[k] && !el_q.prev[k]) |=> pending_o[k]);
    end
endmodule

// File: rtl/rvc_prio_pick.sv
module rvc_prio_pick
    import rvc_pkg::*;
(
    input  logic [NREQ-1:0] vis_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (vis_i[i]) idx_o = IDXW'(i);
        end
        any_o = |vis_i;
    end
endmodule

// File: rtl/rst_vector_intc.sv
module rst_vector_intc
    import rvc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic            cpu_ie_i,
    input  logic            ack_i,
    input  logic            mask_we_i,
    input  logic [NREQ-1:0] mask_wdata_i,
    output logic            int_o,
    output logic [BUSW-1:0] vec_o,
    output logic            vec_oe_o,
    output logic [IDXW-1:0] served_idx_o,
    output logic            served_vld_o
);
    ctl_t            ctl_d, ctl_q;
    logic [NREQ-1:0] pending;
    logic [NREQ-1:0] visible;
    logic [NREQ-1:0] clr;
    logic [IDXW-1:0] pick_idx;
    logic            pick_any;

    rvc_edge_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .clr_i     (clr),
        .pending_o (pending)
    );

    assign visible = pending & ~ctl_q.mask;

    rvc_prio_pick u_pick (
        .vis_i (visible),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    always_comb begin
        ctl_d       = ctl_q;
        clr         = '0;
        ctl_d.svld  = 1'b0;
        ctl_d.int_r = cpu_ie_i & pick_any;
        if (mask_we_i) ctl_d.mask = mask_wdata_i;
        if (ack_i && !ctl_q.active) begin
            ctl_d.active = 1'b1;
            ctl_d.selv   = pick_any;
            ctl_d.sel    = pick_idx;
        end else if (!ack_i && ctl_q.active) begin
            ctl_d.active = 1'b0;
            if (ctl_q.selv) begin
                clr[ctl_q.sel] = 1'b1;
                ctl_d.svld     = 1'b1;
                ctl_d.sidx     = ctl_q.sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign int_o        = ctl_q.int_r;
    assign vec_oe_o     = ctl_q.active & ack_i;
    assign vec_o        = vec_oe_o ? (ctl_q.selv ? rst_opcode(ctl_q.sel) : OP_IDLE) : '0;
    assign served_idx_o = ctl_q.sidx;
    assign served_vld_o = ctl_q.svld;

    // R6
    oe_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> ack_i);

    // R3
    int_follows_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ie_i |=> !int_o);

    // R4
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ack_i) |=> $stable(ctl_q.sel));

    // R7
    served_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        served_vld_o |=> !served_vld_o);

    // R5
    opcode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (vec_o[2:0] == 3'b111 && vec_o[7:6] == 2'b11) || vec_o == OP_IDLE);
endmodule

// File: tb/sim_rst_vector_intc.sv
module sim_rst_vector_intc;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       cpu_ie_i, ack_i, mask_we_i;
    logic [7:0] mask_wdata_i;
    logic       int_o, vec_oe_o, served_vld_o;
    logic [7:0] vec_o;
    logic [2:0] served_idx_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [7:0] m_prev, m_pend, m_mask;
    logic       m_int, m_active, m_selv, m_svld;
    logic [2:0] m_sel, m_sidx;

    rst_vector_intc u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_ie_i(cpu_ie_i),
        .ack_i(ack_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .int_o(int_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o),
        .served_idx_o(served_idx_o), .served_vld_o(served_vld_o)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] lowest(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = 3'(i);
        if (v == 0) lowest = 3'd0;
    endfunction

    function automatic logic [7:0] exp_op(input logic [2:0] n);
        return 8'hC7 + 8'(8 * int'(n));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_pend = 0; m_mask = 0; m_int = 0; m_active = 0;
        m_selv = 0; m_svld = 0; m_sel = 0; m_sidx = 0;
    endtask

    task automatic model_step();
        logic [7:0] vis, clr;
        vis = m_pend & ~m_mask;
        clr = 0;
        m_svld = 0;
        if (ack_i && !m_active) begin
            m_active = 1; m_selv = (vis != 0); m_sel = lowest(vis);
        end else if (!ack_i && m_active) begin
            m_active = 0;
            if (m_selv) begin clr[m_sel] = 1; m_svld = 1; m_sidx = m_sel; end
        end
        m_pend = (m_pend & ~clr) | (req_i & ~m_prev);
        m_prev = req_i;
        m_int  = cpu_ie_i & (vis != 0);
        if (mask_we_i) m_mask = mask_wdata_i;
    endtask

    task automatic compare();
        logic       e_oe;
        logic [7:0] e_vec;
        e_oe  = m_active & ack_i;
        e_vec = e_oe ? (m_selv ? exp_op(m_sel) : 8'h00) : 8'h00;
        chk(int_o == m_int, "R3 int_o", int'(int_o), int'(m_int));
        chk(vec_oe_o == e_oe, "R6 vec_oe_o", int'(vec_oe_o), int'(e_oe));
        chk(vec_o == e_vec, "R5 vec_o", int'(vec_o), int'(e_vec));
        chk(served_vld_o == m_svld, "R7 served_vld_o", int'(served_vld_o), int'(m_svld));
        if (m_svld)
            chk(served_idx_o == m_sidx, "R7 served_idx_o", int'(served_idx_o), int'(m_sidx));
    endtask

    // inputs are applied at negedge; the edge updates both design and model
    task automatic cyc(input logic [7:0] rq, input logic ie, input logic ak,
                       input logic we = 0, input logic [7:0] wd = 0);
        req_i = rq; cpu_ie_i = ie; ack_i = ak; mask_we_i = we; mask_wdata_i = wd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic serve(input logic [7:0] rq_hold);
        cyc(rq_hold, 1, 1);
        cyc(rq_hold, 1, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; req_i = 0; cpu_ie_i = 0; ack_i = 0; mask_we_i = 0; mask_wdata_i = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int_o == 0 && vec_oe_o == 0 && vec_o == 0 && served_vld_o == 0,
            "R1 reset outputs", {int_o, vec_oe_o, served_vld_o}, 0);
        rst_n = 1;

        // R1 mask cleared: request 5 reaches int_o with no mask write
        cyc(8'h20, 1, 0);
        cyc(8'h00, 1, 0);
        chk(int_o == 1, "R1 mask clear after reset", int'(int_o), 1);
        serve(8'h00);
        cyc(8'h00, 1, 0);

        // R5 each opcode / handler address, R7 index
        for (int n = 0; n < 8; n++) begin
            cyc(8'(1 << n), 1, 0);
            cyc(8'h00, 1, 0);
            serve(8'h00);
            chk(vec_o == 8'hC7 + 8'(n * 8), "R5 opcode value", int'(vec_o), 8'hC7 + n * 8);
            chk({vec_o[5:3], 3'b000} == 6'(n * 8), "R5 handler address", int'(vec_o[5:3]) * 8, n * 8);
            cyc(8'h00, 1, 0);
            chk(served_vld_o == 1 && served_idx_o == 3'(n), "R7 served index",
                int'(served_idx_o), n);
        end

        // R2 held line does not retrigger
        cyc(8'h04, 1, 0);
        cyc(8'h04, 1, 0);
        serve(8'h04);
        cyc(8'h04, 1, 0);
        cyc(8'h04, 1, 0);
        cyc(8'h04, 1, 0);
        chk(int_o == 0, "R2 held high no retrigger", int'(int_o), 0);
        cyc(8'h00, 1, 0);

        // R8 masked request captured but hidden
        cyc(8'h00, 1, 0, 1, 8'hFF);
        cyc(8'h08, 1, 0);
        cyc(8'h00, 1, 0);
        cyc(8'h00, 1, 0);
        chk(int_o == 0, "R8 masked hidden", int'(int_o), 0);
        cyc(8'h00, 1, 0, 1, 8'h00);
        cyc(8'h00, 1, 0);
        chk(int_o == 1, "R8 unmasked presented", int'(int_o), 1);

        // R3 ie low drops int within one clock
        cyc(8'h00, 0, 0);
        chk(int_o == 0, "R3 ie low drops int", int'(int_o), 0);
        cyc(8'h00, 1, 0);
        serve(8'h00);
        cyc(8'h00, 1, 0);
        chk(served_idx_o == 3 && served_vld_o, "R8 served after unmask", int'(served_idx_o), 3);

        // R9 empty acknowledge
        cyc(8'h00, 1, 1);
        cyc(8'h00, 1, 1);
        chk(vec_oe_o == 1 && vec_o == 8'h00, "R9 idle opcode", int'(vec_o), 0);
        cyc(8'h00, 1, 0);
        chk(served_vld_o == 0, "R9 no served pulse", int'(served_vld_o), 0);

        // R4 frozen choice while a better request arrives mid-strobe
        cyc(8'h40, 1, 0);
        cyc(8'h00, 1, 0);
        cyc(8'h00, 1, 1);
        cyc(8'h02, 1, 1);
        cyc(8'h00, 1, 1);
        chk(vec_o == 8'hF7, "R4 choice frozen", int'(vec_o), 8'hF7);
        cyc(8'h00, 1, 0);
        chk(served_idx_o == 6, "R4 frozen index served", int'(served_idx_o), 6);
        serve(8'h00);
        chk(vec_o == 8'hCF, "R4 newcomer next", int'(vec_o), 8'hCF);
        cyc(8'h00, 1, 0);

        // random phase
        for (int t = 0; t < 4000; t++) begin
            logic [7:0] rq;
            logic       ie, ak, we;
            rq = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ie = ($urandom % 8) != 0;
            ak = (($urandom % 4) == 0) ? ~ack_i : ack_i;
            we = ($urandom % 40) == 0;
            cyc(rq, ie, ak, we, 8'($urandom) & 8'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule